// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of several DMA channels owns the next transfer slot. Each channel supplies five things: an enable bit, a peripheral request line, a self-trigger bit for memory-to-memory operation, a flag that says its remaining item count is non-zero, and a 2-bit software priority. From these the block forms one internal request per channel. It then grants a single winner. The highest software priority level wins first. Among channels at the same level, the lowest channel index wins.

The grant is a one-hot vector. It goes to the channel engine together with a busy handshake. The engine performs the transfer and pulses a completion input when it is done. A grant is never taken away while its transfer is running. After a completion the grant drops to zero for one cycle. The engine uses that cycle to update its count. The next winner is then chosen from fresh inputs. The channel count is a parameter: the default is seven channels, and a five-channel variant uses the same logic.

Top module: `dma_chan_arbiter`

## Requirements
- R1: The priority field of channel i is `ch_prio[2i+1:2i]`, encoded as 0 = low, 1 = medium, 2 = high, 3 = very high. A requesting channel at a higher level always beats one at a lower level.
- R2: Among requesting channels at the same level, the lowest index wins. Index 0 has the highest fixed priority.
- R3: A channel requests only when `ch_enable[i]` is 1 and either `ch_hw_req[i]` or `ch_mem2mem[i]` is 1. A channel with its enable at 0 is never granted, whatever its other inputs are.
- R4: A channel whose `ch_cnt_nz[i]` is 0 is never granted, even when it is enabled and requesting.
- R5: An enabled channel with `ch_mem2mem[i]` at 1 requests with its hardware line at 0.
- R6: Once a channel is granted, `grant` holds unchanged until a cycle in which `xfer_done` is 1. Higher-priority requests that arrive meanwhile are ignored. In the cycle after that completion, `grant` is zero. Arbitration takes place on the next clock edge.
- R7: `grant` is one-hot or all-zero, and it is all-zero after reset.
- R8: `busy` is 1 exactly when `grant` is non-zero.
- R9: With NUM_CH set to 5, the same rules apply to five channels.
- R10: While no channel requests, `grant` stays zero and `busy` stays low.
- R11: A winner chosen at a clock edge appears on `grant` directly after that edge, with one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_hw_req | input | NUM_CH | Per-channel peripheral request line |
| ch_mem2mem | input | NUM_CH | Per-channel memory-to-memory self-trigger |
| ch_cnt_nz | input | NUM_CH | Per-channel flag: remaining count is non-zero |
| ch_prio | input | NUM_CH*2 | Packed 2-bit software priority per channel |
| xfer_done | input | 1 | Pulse from the engine when the granted transfer ends |
| grant | output | NUM_CH | One-hot grant, held for a whole transfer |
| busy | output | 1 | Transfer in progress |

## Verification
The selector is driven with several request sets, each built to separate one ordering rule from the others. One set has equal levels, so only the index can decide. In another set a higher-indexed channel holds the top level, which shows that the level outranks the index. Other sets contain a very-high channel that is disabled or has a zero count, which shows that the qualifiers act before selection. A set with only the self-trigger shows that memory-to-memory mode needs no peripheral line. A very-high request is also raised in the middle of a transfer, to show that the running grant is held and the newcomer wins only after the release cycle. A five-channel instance confirms that the parameterized variant orders its channels the same way.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int PRIO_W = 2;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;
endpackage

// File: rtl/dma_req_qualify.sv
// Forms each channel's internal request from its raw inputs.
module dma_req_qualify #(
    parameter int NUM_CH = 7
) (
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_hw_req,
    input  logic [NUM_CH-1:0] ch_mem2mem,
    input  logic [NUM_CH-1:0] ch_cnt_nz,
    output logic [NUM_CH-1:0] req
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        // trigger from peripheral or self, then gated by enable and count
        assign req[i] = ch_enable[i] & ch_cnt_nz[i] & (ch_hw_req[i] | ch_mem2mem[i]);
    end
endmodule

// File: rtl/dma_prio_select.sv
// Two-level pick: highest software level first, lowest index inside it.
module dma_prio_select
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic [NUM_CH-1:0]        req,
    input  logic [NUM_CH*PRIO_W-1:0] prio,
    output logic [NUM_CH-1:0]        win,
    output logic                     any
);
    localparam int LEVELS = 1 << PRIO_W;

    logic [LEVELS-1:0][NUM_CH-1:0] lvl_mask;
    logic [NUM_CH-1:0]             top_mask;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            assign lvl_mask[l][i] = req[i] &&
                (prio[i*PRIO_W +: PRIO_W] == PRIO_W'(l));
        end
    end

    always_comb begin
        top_mask = '0;
        for (int l = LEVELS - 1; l >= 0; l--) begin
            if (top_mask == '0) begin
                top_mask = lvl_mask[l];
            end
        end
    end

    // isolate lowest set bit: lowest index wins within the level
    assign win = top_mask & (~top_mask + NUM_CH'(1));
    assign any = |req;
endmodule

// File: rtl/dma_grant_ctrl.sv
// Holds the grant for a whole transfer; re-arbitrates only when idle.
module dma_grant_ctrl
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] win,
    input  logic              any,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] grant,
    output logic              busy
);
    typedef struct packed {
        arb_state_e        st;
        logic [NUM_CH-1:0] gnt;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        unique case (ctrl_q.st)
            ARB_IDLE: begin
                if (any) begin
                    ctrl_d.st  = ARB_BUSY;
                    ctrl_d.gnt = win;
                end
            end
            ARB_BUSY: begin
                if (xfer_done) begin
                    ctrl_d.st  = ARB_IDLE;
                    ctrl_d.gnt = '0;
                end
            end
            default: begin
                ctrl_d.st  = ARB_IDLE;
                ctrl_d.gnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q.st  <= ARB_IDLE;
            ctrl_q.gnt <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign grant = ctrl_q.gnt;
    assign busy  = (ctrl_q.st == ARB_BUSY);
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        ch_enable,
    input  logic [NUM_CH-1:0]        ch_hw_req,
    input  logic [NUM_CH-1:0]        ch_mem2mem,
    input  logic [NUM_CH-1:0]        ch_cnt_nz,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    input  logic                     xfer_done,
    output logic [NUM_CH-1:0]        grant,
    output logic                     busy
);
    logic [NUM_CH-1:0] req;
    logic [NUM_CH-1:0] win;
    logic              any;

    dma_req_qualify #(.NUM_CH(NUM_CH)) u_qual (
        .ch_enable (ch_enable),
        .ch_hw_req (ch_hw_req),
        .ch_mem2mem(ch_mem2mem),
        .ch_cnt_nz (ch_cnt_nz),
        .req       (req)
    );

    dma_prio_select #(.NUM_CH(NUM_CH)) u_sel (
        .req (req),
        .prio(ch_prio),
        .win (win),
        .any (any)
    );

    dma_grant_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .win      (win),
        .any      (any),
        .xfer_done(xfer_done),
        .grant    (grant),
        .busy     (busy)
    );
endmodule

// File: rtl/dma_arb_checker.sv
module dma_arb_checker #(
    parameter int NUM_CH = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_enable,
    input logic [NUM_CH-1:0] ch_cnt_nz,
    input logic              xfer_done,
    input logic [NUM_CH-1:0] grant,
    input logic              busy
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7

    AST_BUSY_TRACKS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (grant != '0)); // R8

    AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !xfer_done) |=> $stable(grant)); // R6

    AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && xfer_done) |=> (grant == '0)); // R6

    AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> (($past(ch_enable) & grant) != '0)); // R3

    AST_GRANT_COUNT_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> (($past(ch_cnt_nz) & grant) != '0)); // R4
endmodule

bind dma_chan_arbiter dma_arb_checker #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ch_enable(ch_enable),
    .ch_cnt_nz(ch_cnt_nz),
    .xfer_done(xfer_done),
    .grant    (grant),
    .busy     (busy)
);

// File: tb/sim_dma_chan_arbiter.sv
`timescale 1ns/1ps
module sim_dma_chan_arbiter;
    localparam int N  = 7;
    localparam int N5 = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [N-1:0]   en, hw, m2m, nz;
    logic [2*N-1:0] prio;
    logic           done;
    logic [N-1:0]   grant;
    logic           busy;

    logic [N5-1:0]   f_en, f_hw, f_m2m, f_nz;
    logic [2*N5-1:0] f_prio;
    logic            f_done;
    logic [N5-1:0]   f_grant;
    logic            f_busy;

    dma_chan_arbiter #(.NUM_CH(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ch_enable(en), .ch_hw_req(hw),
        .ch_mem2mem(m2m), .ch_cnt_nz(nz), .ch_prio(prio),
        .xfer_done(done), .grant(grant), .busy(busy)
    );

    dma_chan_arbiter #(.NUM_CH(N5)) u5 (
        .clk(clk), .rst_n(rst_n), .ch_enable(f_en), .ch_hw_req(f_hw),
        .ch_mem2mem(f_m2m), .ch_cnt_nz(f_nz), .ch_prio(f_prio),
        .xfer_done(f_done), .grant(f_grant), .busy(f_busy)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [N-1:0] exp_q[$];
    string        tag_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares design outputs against queued expectations
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [N-1:0] e;
            string        t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " grant"}, 32'(grant), 32'(e));
            check("R8 busy", 32'(busy), 32'(e != '0));
        end
    end

    task automatic push(input logic [N-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic clear_all();
        en = '0; hw = '0; m2m = '0; nz = '1; prio = '0;
    endtask

    task automatic set_ch(input int i, input bit e, input bit h, input bit m,
                          input bit z, input logic [1:0] p);
        en[i] = e; hw[i] = h; m2m[i] = m; nz[i] = z;
        prio[2*i +: 2] = p;
    endtask

    // one arbitration slot; completes the transfer if a grant is expected
    task automatic run_slot(input logic [N-1:0] e, input string t);
        @(posedge clk);
        push(e, t);
        @(negedge clk);
        if (e != '0) begin
            done = 1'b1;
            @(posedge clk);
            push('0, "R6 release");
            @(negedge clk);
            done = 1'b0;
        end
        clear_all();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        clear_all();
        done = 1'b0;
        f_en = '0; f_hw = '0; f_m2m = '0; f_nz = '1; f_prio = '0; f_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset grant", 32'(grant), 32'h0);
        check("R8 reset busy", 32'(busy), 32'h0);

        // R10: nothing requesting
        run_slot('0, "R10 idle");

        // R2: equal levels, lower index wins
        set_ch(2, 1, 1, 0, 1, 2'd0);
        set_ch(5, 1, 1, 0, 1, 2'd0);
        run_slot(7'b0000100, "R2 tie");

        // R1: very high beats high and medium regardless of index
        set_ch(1, 1, 1, 0, 1, 2'd1);
        set_ch(4, 1, 1, 0, 1, 2'd3);
        set_ch(6, 1, 1, 0, 1, 2'd2);
        run_slot(7'b0010000, "R1 level");
        set_ch(1, 1, 1, 0, 1, 2'd1);
        set_ch(6, 1, 1, 0, 1, 2'd2);
        run_slot(7'b1000000, "R1 high over medium");

        // R3: disabled very-high channel ignored
        set_ch(0, 0, 1, 1, 1, 2'd3);
        set_ch(3, 1, 1, 0, 1, 2'd0);
        run_slot(7'b0001000, "R3 disabled");

        // R4: zero count ignored
        set_ch(0, 1, 1, 0, 0, 2'd3);
        set_ch(5, 1, 1, 0, 1, 2'd0);
        run_slot(7'b0100000, "R4 zero count");

        // R5: self trigger without hardware line
        set_ch(6, 1, 0, 1, 1, 2'd0);
        run_slot(7'b1000000, "R5 mem2mem");
        set_ch(6, 0, 0, 1, 1, 2'd0);
        run_slot('0, "R3 mem2mem disabled");

        // R6/R11: no pre-emption mid-transfer
        set_ch(3, 1, 1, 0, 1, 2'd0);
        @(posedge clk);
        push(7'b0001000, "R11 grant after one edge");
        @(negedge clk);
        set_ch(0, 1, 1, 0, 1, 2'd3);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            push(7'b0001000, "R6 hold");
            @(negedge clk);
        end
        done = 1'b1;
        @(posedge clk);
        push('0, "R6 release gap");
        @(negedge clk);
        done = 1'b0;
        hw[3] = 1'b0;
        run_slot(7'b0000001, "R6 rearbitrate");

        // R9: five-channel variant
        f_en[4] = 1'b1; f_hw[4] = 1'b1; f_prio[9:8] = 2'd3;
        f_en[0] = 1'b1; f_hw[0] = 1'b1; f_prio[1:0] = 2'd0;
        @(posedge clk);
        @(negedge clk);
        check("R9 five-channel grant", 32'(f_grant), 32'h10);
        check("R9 five-channel busy", 32'(f_busy), 32'h1);

        repeat (2) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule